// File: doc/BRIEF.md
# Prefetch Queue Tracking Buffer

A bus monitor watching a processor with an instruction prefetch queue cannot tell from the bus alone which opcode byte is being executed. Fetched code arrives on the data bus well before it runs. This block keeps a byte-wide copy of that queue so that the monitor can follow it. Each fetched 16-bit code word can contribute its low byte, its high byte, or both, through two separate write enables. An execute strobe retires one byte per clock from the head of the queue.

A flush command empties the copy whenever the processor discards its prefetch queue, for example on a jump. The same flush also reloads an execute-address counter from the address bus. That counter then advances by one for every executed byte, so the monitor always holds the address of the byte at the head. The counter value is marked valid only in cycles where no execute strobe is active.

Top module: `pq_track`

## Requirements
- R1: When `exec_byte` is high and the queue is not empty, exactly one byte leaves the head at the rising edge, and `head_byte` then shows the next byte in arrival order.
- R2: `flush` at a rising edge leaves the queue empty (`fill_level` 0, `q_empty` 1) and clears `overflow` and `underflow` in the following cycle.
- R3: `push_lo` enqueues `code_word[7:0]` and `push_hi` enqueues `code_word[15:8]`. When both are high in one cycle, the low byte enters the queue ahead of the high byte.
- R4: Every rising edge with `exec_byte` high and `flush` low increments `exec_addr` by one, whether or not the queue holds data. The counter wraps from 20'hFFFFF to 20'h00000.
- R5: `flush` loads `exec_addr` from `load_addr`. In the same cycle it takes priority over any push, pop or count.
- R6: The queue holds 8 bytes. Free space is judged on the occupancy before any same-cycle pop. Bytes that do not fit are dropped, the low byte being kept when only one slot is free, and `overflow` is high for the one cycle after the edge.
- R7: `exec_byte` on an empty queue leaves the queue unchanged and makes `underflow` high for the one cycle after the edge.
- R8: `addr_valid` is high exactly while `exec_byte` is low.
- R9: After reset the queue is empty, both flags are low and `exec_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor-synchronous clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_word | input | 16 | Fetched code word from the data bus |
| push_lo | input | 1 | Enqueue the low byte of `code_word` |
| push_hi | input | 1 | Enqueue the high byte of `code_word` |
| exec_byte | input | 1 | Execute strobe: pop one byte, advance the address |
| flush | input | 1 | Empty the queue and reload the address counter |
| load_addr | input | 20 | Address loaded into the counter on flush |
| head_byte | output | 8 | Byte at the head of the queue (meaningful when not empty) |
| fill_level | output | 4 | Number of bytes held |
| q_empty | output | 1 | Queue holds no bytes |
| q_full | output | 1 | Queue holds 8 bytes |
| overflow | output | 1 | A byte was dropped at the previous edge |
| underflow | output | 1 | A pop hit an empty queue at the previous edge |
| exec_addr | output | 20 | Address of the byte at the head of execution |
| addr_valid | output | 1 | `exec_addr` may be sampled this cycle |

## Verification
The bench fills the queue with low-only, high-only and paired pushes, then checks the byte order. A design that enqueued the high byte first, or wrote both bytes to one slot, would show the wrong head after each pop. The bench pushes a pair into a full queue during a pop, and again into a queue with a single free slot. A design that let the pop free space early, or that kept the high byte instead of the low, would report a different fill level or head. Further cases combine a flush with a push and a pop, wrap the counter at its top value, and pop an empty queue. Each of these catches a priority mistake, a counter that saturates, or a pointer that moves on an illegal pop.

// File: rtl/pq_track.sv
module pq_track #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int AW    = 20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DW-1:0]                code_word,
  input  logic                         push_lo,
  input  logic                         push_hi,
  input  logic                         exec_byte,
  input  logic                         flush,
  input  logic [AW-1:0]                load_addr,
  output logic [DW/2-1:0]              head_byte,
  output logic [$clog2(DEPTH+1)-1:0]   fill_level,
  output logic                         q_empty,
  output logic                         q_full,
  output logic                         overflow,
  output logic                         underflow,
  output logic [AW-1:0]                exec_addr,
  output logic                         addr_valid
);
  localparam int BW = DW / 2;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [BW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;

  wire [CW-1:0] space  = CW'(DEPTH) - cnt;
  wire          pop_ok = exec_byte && (cnt != '0);
  wire          lo_ok  = push_lo && (space != '0);
  wire          hi_ok  = push_hi && (push_lo ? (space >= CW'(2)) : (space != '0));
  wire          drop   = (push_lo && !lo_ok) || (push_hi && !hi_ok);
  wire [PW-1:0] hi_slot = wr_ptr + PW'(lo_ok);
  wire [CW-1:0] n_in   = CW'(lo_ok) + CW'(hi_ok);

  always_ff @(posedge clk) begin
    if (!flush) begin
      if (lo_ok) mem[wr_ptr]  <= code_word[BW-1:0];
      if (hi_ok) mem[hi_slot] <= code_word[DW-1:BW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      cnt       <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      exec_addr <= '0;
    end else if (flush) begin
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      cnt       <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      exec_addr <= load_addr;
    end else begin
      rd_ptr    <= rd_ptr + PW'(pop_ok);
      wr_ptr    <= wr_ptr + PW'(n_in);
      cnt       <= cnt + n_in - CW'(pop_ok);
      overflow  <= drop;
      underflow <= exec_byte && (cnt == '0);
      exec_addr <= exec_addr + AW'(exec_byte);
    end
  end

  assign head_byte  = mem[rd_ptr];
  assign fill_level = cnt;
  assign q_empty    = (cnt == '0);
  assign q_full     = (cnt == CW'(DEPTH));
  assign addr_valid = !exec_byte;

  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && exec_byte && !q_empty && !push_lo && !push_hi) |=> fill_level == $past(fill_level) - CW'(1)); // R1
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (q_empty && !overflow && !underflow)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && exec_byte) |=> exec_addr == $past(exec_addr) + AW'(1)); // R4
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> exec_addr == $past(load_addr)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CW'(DEPTH)); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && q_full && (push_lo || push_hi)) |=> overflow); // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && exec_byte && q_empty && !push_lo && !push_hi) |=> (underflow && q_empty)); // R7
endmodule

// File: tb/pq_track_tb.sv
module pq_track_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] code_word = '0;
  logic        push_lo = 1'b0, push_hi = 1'b0, exec_byte = 1'b0, flush = 1'b0;
  logic [19:0] load_addr = '0;
  logic [7:0]  head_byte;
  logic [3:0]  fill_level;
  logic        q_empty, q_full, overflow, underflow, addr_valid;
  logic [19:0] exec_addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pq_track dut_i (
    .clk(clk), .rst_n(rst_n), .code_word(code_word), .push_lo(push_lo),
    .push_hi(push_hi), .exec_byte(exec_byte), .flush(flush), .load_addr(load_addr),
    .head_byte(head_byte), .fill_level(fill_level), .q_empty(q_empty), .q_full(q_full),
    .overflow(overflow), .underflow(underflow), .exec_addr(exec_addr), .addr_valid(addr_valid)
  );

  // {flush, lo, hi, pop, word, exp_fill, exp_head, exp_ovf, exp_unf}
  localparam logic [33:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,1'b0,16'h1122,4'd1,8'h22,1'b0,1'b0}, // R3 low only
    {1'b0,1'b0,1'b1,1'b0,16'h3344,4'd2,8'h22,1'b0,1'b0}, // R3 high only
    {1'b0,1'b1,1'b1,1'b0,16'h5566,4'd4,8'h22,1'b0,1'b0}, // R3 pair
    {1'b0,1'b0,1'b0,1'b1,16'h0000,4'd3,8'h33,1'b0,1'b0}, // R1
    {1'b0,1'b0,1'b0,1'b1,16'h0000,4'd2,8'h66,1'b0,1'b0}, // R1/R3 low first
    {1'b0,1'b0,1'b0,1'b1,16'h0000,4'd1,8'h55,1'b0,1'b0}, // R1
    {1'b0,1'b1,1'b1,1'b1,16'h7788,4'd2,8'h88,1'b0,1'b0}, // R1/R3 pop+push
    {1'b0,1'b1,1'b1,1'b0,16'h99AA,4'd4,8'h88,1'b0,1'b0},
    {1'b0,1'b1,1'b1,1'b0,16'hBBCC,4'd6,8'h88,1'b0,1'b0},
    {1'b0,1'b1,1'b1,1'b0,16'hDDEE,4'd8,8'h88,1'b0,1'b0}, // R6 full
    {1'b0,1'b1,1'b0,1'b0,16'h00F0,4'd8,8'h88,1'b1,1'b0}, // R6 drop
    {1'b0,1'b1,1'b1,1'b1,16'h1234,4'd7,8'h77,1'b1,1'b0}, // R6 space before pop
    {1'b0,1'b1,1'b1,1'b0,16'h5678,4'd8,8'h77,1'b1,1'b0}, // R6 low kept
    {1'b1,1'b1,1'b0,1'b1,16'hABCD,4'd0,8'h00,1'b0,1'b0}, // R2/R5 flush wins
    {1'b0,1'b0,1'b0,1'b1,16'h0000,4'd0,8'h00,1'b0,1'b1}, // R7
    {1'b0,1'b0,1'b1,1'b0,16'hEF01,4'd1,8'hEF,1'b0,1'b0}, // R3/R7 intact
    {1'b0,1'b0,1'b0,1'b1,16'h0000,4'd0,8'h00,1'b0,1'b0}  // R1
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input bit f, input bit l, input bit h, input bit p, input logic [15:0] w, input logic [19:0] a);
    flush = f; push_lo = l; push_hi = h; exec_byte = p; code_word = w; load_addr = a;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(fill_level == 0 && q_empty && !q_full, "R9 fill", 32'(fill_level), 0);
    check(!overflow && !underflow, "R9 flags", {overflow, underflow}, 0);
    check(exec_addr == 0, "R9 addr", exec_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][33], VEC[i][32], VEC[i][31], VEC[i][30], VEC[i][29:14], 20'h0);
      tick();
      check(fill_level == VEC[i][13:10], $sformatf("R1/R6 fill v%0d", i), 32'(fill_level), 32'(VEC[i][13:10]));
      if (VEC[i][13:10] != 0)
        check(head_byte == VEC[i][9:2], $sformatf("R3 head v%0d", i), 32'(head_byte), 32'(VEC[i][9:2]));
      check(overflow == VEC[i][1], $sformatf("R6 ovf v%0d", i), 32'(overflow), 32'(VEC[i][1]));
      check(underflow == VEC[i][0], $sformatf("R7 unf v%0d", i), 32'(underflow), 32'(VEC[i][0]));
      if (VEC[i][13:10] == 8) check(q_full, "R6 full flag", 32'(q_full), 1);
    end

    drive(1, 0, 0, 0, 16'h0, 20'hFFFFE);
    tick();
    check(exec_addr == 20'hFFFFE, "R5 load", exec_addr, 20'hFFFFE);
    drive(0, 0, 0, 1, 16'h0, 20'h0);
    #1;
    check(addr_valid == 1'b0, "R8 strobe high", 32'(addr_valid), 0);
    tick();
    check(exec_addr == 20'hFFFFF, "R4 step empty", exec_addr, 20'hFFFFF);
    tick();
    check(exec_addr == 20'h00000, "R4 wrap", exec_addr, 0);
    drive(0, 0, 0, 0, 16'h0, 20'h0);
    #1;
    check(addr_valid == 1'b1, "R8 strobe low", 32'(addr_valid), 1);
    drive(0, 1, 1, 0, 16'hC3A5, 20'h0);
    tick();
    drive(1, 1, 1, 1, 16'h1111, 20'h12345);
    tick();
    check(exec_addr == 20'h12345 && q_empty, "R5 flush priority", exec_addr, 20'h12345);
    drive(0, 0, 0, 0, 16'h0, 20'h0);
    tick();
    check(exec_addr == 20'h12345, "R4 hold without strobe", exec_addr, 20'h12345);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule